// File: doc/BRIEF.md
# Prescaled Reload Timer with Compare and Trigger Output

This block is an up-counting timer with a small synchronous register port. A run bit gates counting. An optional power-of-two prescaler slows the count. When the counter passes its all-ones value it either restarts from a load value or stops. A compare register raises a match event. The block also receives a capture pulse from a separate capture unit.

Three sticky status flags record match, overflow and capture events. Software clears each flag by writing 1 to it. Per-flag enable bits combine the flags into one interrupt line. A trigger output follows overflow events, or overflow and match events. It can pulse or toggle, and it rests at a programmable level whenever it is inactive.

Register map (word address on `addr`): 0 control, 1 status, 2 interrupt enable, 3 counter, 4 load value, 5 reload trigger (write only, reads 0), 6 match value. Control bits: bit 0 run, bit 1 reload mode, bit 2 prescaler enable, bits 5:3 prescale exponent, bit 6 compare enable, bit 7 idle level, bits 9:8 trigger source, bit 10 toggle select. Status and enable bits: bit 0 match, bit 1 overflow, bit 2 capture. Reads are combinational on `addr`, and writes take effect at the next rising clock edge.

Top module: `reload_timer`

## Requirements
- R1: The counter advances only while control bit 0 (run) is 1. While run is 0, the counter holds its value.
- R2: One clock after the counter reaches all ones, the next count overflows and sets status bit 1. With control bit 1 = 1, the counter takes the load value (address 4). With control bit 1 = 0, the counter goes to 0 and run clears to 0.
- R3: With control bit 2 = 1, the counter advances once every 2^(E+1) clocks, where E is control bits 5:3. With control bit 2 = 0, it advances on every clock.
- R4: With control bit 6 = 1, the count step that makes the counter equal to the match value (address 6) sets status bit 0. With control bit 6 = 0, no match flag is raised.
- R5: A status bit reads 1 while its event is pending. Writing 1 to a status bit clears it, and writing 0 to it leaves it unchanged.
- R6: Control bits 9:8 select the trigger source: 0 = none, 1 = overflow, 2 = overflow or match, 3 = none.
- R7: While run is 0, or the trigger source is none, `tmr_out` equals control bit 7.
- R8: With control bit 10 = 0, each trigger event drives `tmr_out` to the inverse of the idle level for the one clock after the event. With control bit 10 = 1, each trigger event inverts `tmr_out`, starting from the idle level.
- R9: `irq` is high exactly when some status bit and its enable bit (address 2, same bit order) are both 1.
- R10: A write to address 3 loads the counter directly. A write to address 5 copies the load value into the counter. Neither write changes any status flag.
- R11: If an overflow and a write-1-to-clear of the overflow flag happen in the same clock, the flag stays set.
- R12: A one-clock pulse on `cap_evt` sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` |
| cap_evt | input | 1 | Capture event pulse from the capture unit |
| irq | output | 1 | Combined interrupt |
| tmr_out | output | 1 | Pulse/toggle trigger output |

## Verification
The bench builds the block with its defaults: a 32-bit counter and a 3-bit prescale exponent. With these values all eight prescale divisions, from 2 to 256, can be swept in full, and the count after each window is predicted from the division factor. The counter is preloaded just below all ones so that overflow and reload occur within a few clocks. This also lets the bench line up a clear of the overflow flag with the overflow itself, and gives a two-clock overflow period on which the pulse and toggle outputs are checked cycle by cycle.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CW   = 32,
  parameter int PEXP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          cap_evt,
  output logic          irq,
  output logic          tmr_out
);
  localparam int PW     = 1 << PEXP;
  localparam int B_CMP  = 3 + PEXP;
  localparam int B_IDL  = B_CMP + 1;
  localparam int B_TRG  = B_IDL + 1;
  localparam int B_TGL  = B_TRG + 2;
  localparam logic [2:0] A_CTL = 3'd0, A_STA = 3'd1, A_IEN = 3'd2,
                         A_CNT = 3'd3, A_LD  = 3'd4, A_TRG = 3'd5, A_MAT = 3'd6;

  logic            run_q, rld_q, pre_q, cmp_q, idl_q, tsel_q;
  logic [PEXP-1:0] ptv_q;
  logic [1:0]      trg_q;
  logic [2:0]      flg_q, ien_q;
  logic [CW-1:0]   cnt_q, load_q, mat_q;
  logic [PW-1:0]   psc_q, psc_lim;
  logic            pls_q, tg_q;

  logic wr_ctl, wr_sta, cnt_wr, tick, ovf, mat_evt, active, trig;
  logic [CW-1:0] cnt_adv;
  logic [2:0] clr;

  assign wr_ctl = wr_en && addr == A_CTL;
  assign wr_sta = wr_en && addr == A_STA;
  assign cnt_wr = wr_en && (addr == A_CNT || addr == A_TRG);

  assign psc_lim = ({{(PW-1){1'b0}}, 1'b1} << ptv_q << 1) - {{(PW-1){1'b0}}, 1'b1};
  assign tick    = run_q && !cnt_wr && (!pre_q || psc_q == psc_lim);
  assign ovf     = tick && (&cnt_q);
  assign cnt_adv = ovf ? (rld_q ? load_q : '0) : cnt_q + 1'b1;
  assign mat_evt = tick && cmp_q && cnt_adv == mat_q;
  assign clr     = wr_sta ? wdata[2:0] : 3'b000;

  assign active  = run_q && (trg_q == 2'd1 || trg_q == 2'd2);
  assign trig    = ovf || (trg_q == 2'd2 && mat_evt);
  assign tmr_out = active ? (tsel_q ? tg_q : (idl_q ^ pls_q)) : idl_q;
  assign irq     = |(flg_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; rld_q <= 1'b0; pre_q <= 1'b0; cmp_q <= 1'b0;
      idl_q <= 1'b0; tsel_q <= 1'b0; ptv_q <= '0; trg_q <= 2'd0;
    end else if (wr_ctl) begin
      run_q  <= wdata[0];
      rld_q  <= wdata[1];
      pre_q  <= wdata[2];
      ptv_q  <= wdata[3 +: PEXP];
      cmp_q  <= wdata[B_CMP];
      idl_q  <= wdata[B_IDL];
      trg_q  <= wdata[B_TRG +: 2];
      tsel_q <= wdata[B_TGL];
    end else if (ovf && !rld_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; load_q <= '0; mat_q <= '0;
    end else if (wr_en) begin
      if (addr == A_IEN) ien_q  <= wdata[2:0];
      if (addr == A_LD)  load_q <= wdata;
      if (addr == A_MAT) mat_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             psc_q <= '0;
    else if (!run_q || !pre_q || cnt_wr)    psc_q <= '0;
    else if (psc_q == psc_lim)              psc_q <= '0;
    else                                    psc_q <= psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (wr_en && addr == A_CNT)         cnt_q <= wdata;
    else if (wr_en && addr == A_TRG)         cnt_q <= load_q;
    else if (tick)                           cnt_q <= cnt_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~clr) | {cap_evt, ovf, mat_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= 1'b0; tg_q <= 1'b0;
    end else begin
      pls_q <= active && trig;
      if (!active)   tg_q <= idl_q;
      else if (trig) tg_q <= ~tg_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL: begin
        rdata[0] = run_q; rdata[1] = rld_q; rdata[2] = pre_q;
        rdata[3 +: PEXP] = ptv_q; rdata[B_CMP] = cmp_q; rdata[B_IDL] = idl_q;
        rdata[B_TRG +: 2] = trg_q; rdata[B_TGL] = tsel_q;
      end
      A_STA:   rdata[2:0] = flg_q;
      A_IEN:   rdata[2:0] = ien_q;
      A_CNT:   rdata = cnt_q;
      A_LD:    rdata = load_q;
      A_MAT:   rdata = mat_q;
      default: rdata = '0;
    endcase
  end
endmodule

module reload_timer_chk #(parameter int CW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] cnt_q,
  input logic          run_q,
  input logic          rld_q,
  input logic          idl_q,
  input logic [2:0]    flg_q,
  input logic [2:0]    ien_q,
  input logic          irq,
  input logic          tmr_out
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && (addr == 3'd3 || addr == 3'd5))) |=> $stable(cnt_q));

  p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flg_q[1]) && !$past(rld_q) && !$past(wr_en && addr == 3'd0)) |-> !run_q);

  p_sticky_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[0] && !(wr_en && addr == 3'd1 && wdata[0])) |=> flg_q[0]);

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> tmr_out == idl_q);

  p_no_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 3'b000) |-> !irq);
endmodule

bind reload_timer reload_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_q(cnt_q), .run_q(run_q), .rld_q(rld_q), .idl_q(idl_q),
  .flg_q(flg_q), .ien_q(ien_q), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cap_evt = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic irq, tmr_out;
  int total = 0, bad = 0;

  reload_timer u_reload_timer (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cap_evt(cap_evt), .irq(irq), .tmr_out(tmr_out));

  always #(CLK_P/2) clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_n(2); rst_n = 1'b1; wait_n(1);
    rd(3'd0, v); chk("reset ctrl", v, 0);
    rd(3'd3, v); chk("reset count", v, 0);
    chk("reset out R7", {31'b0, tmr_out}, 0);

    // R1/R3: no prescaler, then every exponent
    wr(3'd3, 0); wr(3'd0, 32'h1); wait_n(10);
    rd(3'd3, v); chk("R3 undivided", v, 10);
    wr(3'd0, 0); wait_n(5);
    rd(3'd3, v); chk("R1 hold stopped", v, 11);
    for (int p = 0; p < 8; p++) begin
      int d;
      d = 2 << p;
      wr(3'd0, 0); wr(3'd3, 0);
      wr(3'd0, 32'h5 | (p << 3));
      wait_n(3*d - 1);
      rd(3'd3, v); chk($sformatf("R3 exp=%0d before edge", p), v, 2);
      wait_n(1);
      rd(3'd3, v); chk($sformatf("R3 exp=%0d at edge", p), v, 3);
    end

    // R2 reload
    wr(3'd0, 0); wr(3'd4, 32'h100); wr(3'd3, 32'hFFFF_FFFE); wr(3'd1, 7);
    wr(3'd0, 32'h3); wait_n(1);
    rd(3'd3, v); chk("R2 top", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R2 no flag yet", v, 0);
    wait_n(1);
    rd(3'd3, v); chk("R2 reload value", v, 32'h100);
    rd(3'd1, v); chk("R2 ovf flag", v, 2);
    rd(3'd0, v); chk("R2 still running", v & 1, 1);

    // R2 one-shot
    wr(3'd0, 0); wr(3'd1, 2); wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 32'h1); wait_n(2);
    rd(3'd3, v); chk("R2 oneshot zero", v, 0);
    rd(3'd0, v); chk("R2 oneshot stopped", v & 1, 0);
    rd(3'd1, v); chk("R2 oneshot flag", v, 2);
    wait_n(3);
    rd(3'd3, v); chk("R1 hold after oneshot", v, 0);

    // R11 event beats clear
    wr(3'd0, 0); wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 32'h3); wait_n(1);
    wr(3'd1, 2);
    rd(3'd1, v); chk("R11 event wins", v & 2, 2);
    wr(3'd1, 2);
    rd(3'd1, v); chk("R5 clear alone", v & 2, 0);

    // R4 compare
    wr(3'd0, 0); wr(3'd1, 7); wr(3'd3, 0); wr(3'd6, 5); wr(3'd0, 32'h41); wait_n(4);
    rd(3'd1, v); chk("R4 before match", v & 1, 0);
    wait_n(1);
    rd(3'd3, v); chk("R4 count at match", v, 5);
    rd(3'd1, v); chk("R4 match flag", v & 1, 1);
    wr(3'd1, 0);
    rd(3'd1, v); chk("R5 write 0 keeps", v & 1, 1);
    wr(3'd1, 1);
    rd(3'd1, v); chk("R5 write 1 clears", v & 1, 0);
    wr(3'd0, 0); wr(3'd3, 0); wr(3'd0, 32'h1); wait_n(6);
    rd(3'd1, v); chk("R4 compare disabled", v & 1, 0);

    // R12 / R9
    wr(3'd0, 0); wr(3'd1, 7); wr(3'd2, 4);
    cap_evt = 1'b1; wait_n(1); cap_evt = 1'b0;
    rd(3'd1, v); chk("R12 capture flag", v, 4);
    chk("R9 irq enabled", {31'b0, irq}, 1);
    wr(3'd2, 3); chk("R9 irq other enables", {31'b0, irq}, 0);
    wr(3'd2, 0); chk("R9 irq none", {31'b0, irq}, 0);
    wr(3'd1, 7);

    // R10
    wr(3'd4, 32'h40); wr(3'd3, 32'h7);
    rd(3'd3, v); chk("R10 direct load", v, 7);
    wr(3'd5, 0);
    rd(3'd3, v); chk("R10 trigger reload", v, 32'h40);
    rd(3'd1, v); chk("R10 flags untouched", v, 0);

    // R8 pulse
    wr(3'd4, 32'hFFFF_FFFE); wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd0, 32'h103);
    chk("R8 pulse E0", {31'b0, tmr_out}, 0);
    for (int k = 1; k <= 4; k++) begin
      wait_n(1);
      chk($sformatf("R8 pulse E%0d", k), {31'b0, tmr_out}, (k % 2 == 0) ? 1 : 0);
    end
    // R8 toggle
    wr(3'd0, 0); wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 32'h503);
    chk("R8 toggle E0", {31'b0, tmr_out}, 0);
    for (int k = 1; k <= 4; k++) begin
      wait_n(1);
      chk($sformatf("R8 toggle E%0d", k), {31'b0, tmr_out}, ((k / 2) % 2 == 1) ? 1 : 0);
    end

    // R7 idle level
    wr(3'd0, 32'h80);
    chk("R7 stopped idle high", {31'b0, tmr_out}, 1);
    wr(3'd3, 32'hFFFF_FFFE); wr(3'd0, 32'h383);
    for (int k = 1; k <= 4; k++) begin
      wait_n(1);
      chk($sformatf("R6 code3 idle E%0d", k), {31'b0, tmr_out}, 1);
    end

    // R6 match source vs overflow-only
    wr(3'd0, 0); wr(3'd4, 0); wr(3'd3, 0); wr(3'd6, 2); wr(3'd0, 32'h243);
    wait_n(2); chk("R6 match pulse", {31'b0, tmr_out}, 1);
    wait_n(1); chk("R6 match pulse end", {31'b0, tmr_out}, 0);
    wr(3'd0, 0); wr(3'd3, 0); wr(3'd0, 32'h143);
    wait_n(2); chk("R6 overflow-only ignores match", {31'b0, tmr_out}, 0);
    wr(3'd0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule